// File: doc/BRIEF.md
# Keyed Command Engine

This block executes single device commands issued by a host through a small register file. The host first loads a target device address, a transfer size in bytes and a transmit data word. It then writes a command word whose upper half carries a protection key and whose low nibble selects a command mode. The command runs only when the key matches. Each running command is carried out as one or more accesses on a device port. The actual pin timing is abstracted to a request/acknowledge handshake with a device stub.

The device port can be configured 8, 16 or 32 bits wide. A transfer larger than the port is split into successive port-width accesses, and the device address steps forward by the port width for each one. The memory kind selected on the configuration inputs decides whether a mode counts as a read, a write or a data-less control command. A read assembles the returned bytes into the receive register. A write drives the transmit word onto the port. Completion and errors are reported through sticky write-1-to-clear status flags, and a live idle bit sits beside them.

Top module: `kcmd_engine`

## Requirements
- R1: A write to the command register (offset 3) executes only when bits [31:16] equal the key parameter (default 0xA55A). With any other key the write produces no device access and changes neither the done nor the error flag.
- R2: An accepted command whose size field is 0, 5, 6 or 7 makes no device access and sets both the done and error flags in the following cycle.
- R3: The size register (offset 1) holds the size in bits [2:0]. It reads back lane masks that are derived, not stored: bit 4 = size < 2 (lane 1 unused), bit 5 = size < 3 (lane 2 unused), bit 6 = size < 4 (lane 3 unused).
- R4: A legal command of S bytes on a port of P bytes makes ceil(S/P) accesses, the i-th at address base + i*P. Port code 0 means 8 bits, 1 means 16 bits, and 2 or 3 mean 32 bits. Requests hold their address and lanes until acknowledged.
- R5: Byte k of a data word occupies bits [8k+7:8k]. Access i carries bytes i*P.. on port lanes 0..P-1, and a lane enable is set only for bytes below S. Lanes at or above P are never enabled.
- R6: The receive register (offset 4) is loaded only when a read-class command completes: byte b < S holds the byte returned for it, and bytes at or above S read as zero. Other commands leave it unchanged.
- R7: The transmit word (offset 2) drives enabled write-data lanes only for write-class commands; otherwise device write data is zero.
- R8: Read/write class is decoded from mode and memory kind. Kind 0: read 8, write 9 and 10. Kind 1: read 2, write 3. Kind 2: read 0 and 2, write 1 and 3. Kind 3: read 4, 5 and 6, write 1, 2 and 3. Any other mode is a control command with neither direction asserted.
- R9: Status (offset 5): bit 0 done, set when the last access is acknowledged; bit 1 error; bit 2 idle. Writing 1 to bit 0 or bit 1 clears that flag alone.
- R10: A keyed command write while a command is in progress is rejected, sets the error flag one cycle later, and does not disturb the running command.
- R11: After reset all registers read zero except status, which reads idle (0x4), and the size register, which reads 0x70.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_we | input | 1 | Host register write strobe |
| hst_addr | input | 3 | Host register offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for hst_addr (combinational) |
| cfg_kind | input | 2 | Memory kind, sampled when a command is accepted |
| cfg_port | input | 2 | Port width code, sampled when a command is accepted |
| dev_req | output | 1 | Device access request |
| dev_addr | output | ADDR_W | Device byte address of the current access |
| dev_write | output | 1 | Current command is write-class |
| dev_read | output | 1 | Current command is read-class |
| dev_mode | output | 4 | Command mode of the running command |
| dev_be | output | 4 | Per-lane enables of the current access |
| dev_wdata | output | 32 | Device write data lanes |
| dev_ack | input | 1 | Device acknowledge of the current access |
| dev_rdata | input | 32 | Device read data lanes, valid with dev_ack |

## Verification
A wrong beat counter or a wrong offset shift shows up on the first acknowledged access. The device address, the lane enables or the write data then differ from the model at that very handshake. A wrong final-beat decision shows up as an extra or a missing access, and the done flag then rises a whole stub latency early or late. A bad lane merge stays hidden until the command completes, when the receive register reads back the wrong byte. A stuck busy state appears as an idle bit that never returns, and a mis-decoded key or size appears in the status read one cycle after the command write.

// File: rtl/kcmd_pkg.sv
package kcmd_pkg;
   localparam int LANES  = 4;
   localparam int WORD_W = 8 * LANES;
   localparam int SZ_W   = 3;
   localparam int BEAT_W = 2;
   localparam int MODE_W = 4;

   localparam logic [2:0] OFS_ADDR = 3'd0;
   localparam logic [2:0] OFS_SIZE = 3'd1;
   localparam logic [2:0] OFS_TXD  = 3'd2;
   localparam logic [2:0] OFS_CMD  = 3'd3;
   localparam logic [2:0] OFS_RXD  = 3'd4;
   localparam logic [2:0] OFS_STAT = 3'd5;

   localparam int ST_DONE = 0;
   localparam int ST_ERR  = 1;
   localparam int ST_IDLE = 2;

   typedef enum logic [1:0] {
      KIND_SDR  = 2'd0,
      KIND_NOR  = 2'd1,
      KIND_SRAM = 2'd2,
      KIND_NAND = 2'd3
   } mem_kind_e;

   // log2 of port width in bytes; codes above 2 clamp to the full word
   function automatic logic [1:0] port_shift(input logic [1:0] code);
      case (code)
         2'd0:    return 2'd0;
         2'd1:    return 2'd1;
         default: return 2'd2;
      endcase
   endfunction

   function automatic logic size_legal(input logic [SZ_W-1:0] sz);
      return (sz != '0) && (sz <= SZ_W'(LANES));
   endfunction

   // {lane3, lane2, lane1} unused flags
   function automatic logic [2:0] lane_unused(input logic [SZ_W-1:0] sz);
      return {sz < 3'd4, sz < 3'd3, sz < 3'd2};
   endfunction
endpackage

// File: rtl/kcmd_classify.sv
module kcmd_classify
   import kcmd_pkg::*;
(
   input  logic [1:0]        kind,
   input  logic [MODE_W-1:0] mode,
   output logic              is_rd,
   output logic              is_wr
);
   always_comb begin
      is_rd = 1'b0;
      is_wr = 1'b0;
      case (mem_kind_e'(kind))
         KIND_SDR: begin
            is_rd = (mode == 4'd8);
            is_wr = (mode == 4'd9) || (mode == 4'd10);
         end
         KIND_NOR: begin
            is_rd = (mode == 4'd2);
            is_wr = (mode == 4'd3);
         end
         KIND_SRAM: begin
            is_rd = (mode == 4'd0) || (mode == 4'd2);
            is_wr = (mode == 4'd1) || (mode == 4'd3);
         end
         default: begin
            is_rd = (mode >= 4'd4) && (mode <= 4'd6);
            is_wr = (mode >= 4'd1) && (mode <= 4'd3);
         end
      endcase
   end
endmodule

// File: rtl/kcmd_regs.sv
module kcmd_regs
   import kcmd_pkg::*;
#(
   parameter int              ADDR_W  = 32,
   parameter int              KEY_W   = 16,
   parameter logic [KEY_W-1:0] CMD_KEY = 16'hA55A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_we,
   input  logic [2:0]        hst_addr,
   input  logic [31:0]       hst_wdata,
   output logic [31:0]       hst_rdata,
   input  logic              idle,
   input  logic              set_done,
   input  logic              set_err,
   input  logic              rx_load,
   input  logic [WORD_W-1:0] rx_val,
   output logic [ADDR_W-1:0] addr_q,
   output logic [SZ_W-1:0]   size_q,
   output logic [WORD_W-1:0] tx_q,
   output logic              cmd_go,
   output logic [MODE_W-1:0] cmd_mode,
   output logic              done_q,
   output logic              err_q
);
   logic [WORD_W-1:0] rx_q;
   logic [31:0]       addr_rd;
   logic              w1c;

   assign w1c      = hst_we && (hst_addr == OFS_STAT);
   assign cmd_go   = hst_we && (hst_addr == OFS_CMD) && (hst_wdata[31 -: KEY_W] == CMD_KEY);
   assign cmd_mode = hst_wdata[MODE_W-1:0];

   generate
      if (ADDR_W == 32) begin : g_addr_full
         assign addr_rd = addr_q;
      end else begin : g_addr_ext
         assign addr_rd = {{(32-ADDR_W){1'b0}}, addr_q};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         size_q <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (hst_we && hst_addr == OFS_ADDR) addr_q <= hst_wdata[ADDR_W-1:0];
         if (hst_we && hst_addr == OFS_SIZE) size_q <= hst_wdata[SZ_W-1:0];
         if (hst_we && hst_addr == OFS_TXD)  tx_q   <= hst_wdata[WORD_W-1:0];
         if (rx_load) rx_q <= rx_val;
         done_q <= set_done | (done_q & ~(w1c & hst_wdata[ST_DONE]));
         err_q  <= set_err  | (err_q  & ~(w1c & hst_wdata[ST_ERR]));
      end
   end

   always_comb begin
      case (hst_addr)
         OFS_ADDR: hst_rdata = addr_rd;
         OFS_SIZE: hst_rdata = {25'd0, lane_unused(size_q), 1'b0, size_q};
         OFS_TXD:  hst_rdata = tx_q;
         OFS_RXD:  hst_rdata = rx_q;
         OFS_STAT: hst_rdata = {29'd0, idle, err_q, done_q};
         default:  hst_rdata = 32'd0;
      endcase
   end
endmodule

// File: rtl/kcmd_seq.sv
module kcmd_seq
   import kcmd_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [MODE_W-1:0] mode,
   input  logic [1:0]        kind,
   input  logic [1:0]        port_code,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SZ_W-1:0]   size,
   input  logic [WORD_W-1:0] tx,
   input  logic              dev_ack,
   input  logic [WORD_W-1:0] dev_rdata,
   output logic              idle,
   output logic              set_done,
   output logic              set_err,
   output logic              rx_load,
   output logic [WORD_W-1:0] rx_val,
   output logic              dev_req,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              dev_write,
   output logic              dev_read,
   output logic [MODE_W-1:0] dev_mode,
   output logic [LANES-1:0]  dev_be,
   output logic [WORD_W-1:0] dev_wdata
);
   logic              busy_q, rd_q, wr_q;
   logic [ADDR_W-1:0] base_q;
   logic [SZ_W-1:0]   size_lq;
   logic [WORD_W-1:0] tx_lq, acc_q, merged;
   logic [1:0]        shift_q;
   logic [MODE_W-1:0] mode_q;
   logic [BEAT_W-1:0] beat_q;
   logic [2:0]        off, span;
   logic [3:0]        reach;
   logic              last, accept, c_rd, c_wr;
   logic [LANES-1:0]  en;
   logic [1:0]        lane_idx [LANES];

   kcmd_classify u_cls (.kind(kind), .mode(mode), .is_rd(c_rd), .is_wr(c_wr));

   assign off    = 3'(beat_q) << shift_q;
   assign span   = 3'd1 << shift_q;
   assign reach  = {1'b0, off} + {1'b0, span};
   assign last   = reach >= {1'b0, size_lq};
   assign accept = start && !busy_q && size_legal(size);

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         logic [3:0] idx;
         assign idx           = {1'b0, off} + 4'(j);
         assign lane_idx[j]   = idx[1:0];
         assign en[j]         = (3'(j) < span) && (idx < {1'b0, size_lq});
         assign dev_be[j]     = busy_q && en[j];
         assign dev_wdata[8*j +: 8] = (busy_q && wr_q && en[j]) ? tx_lq[8*idx[1:0] +: 8] : 8'h00;
      end
   endgenerate

   always_comb begin
      merged = acc_q;
      for (int j = 0; j < LANES; j++)
         if (en[j]) merged[8*lane_idx[j] +: 8] = dev_rdata[8*j +: 8];
   end

   assign idle      = !busy_q;
   assign dev_req   = busy_q;
   assign dev_addr  = base_q + ADDR_W'(off);
   assign dev_write = busy_q && wr_q;
   assign dev_read  = busy_q && rd_q;
   assign dev_mode  = mode_q;
   assign set_done  = (busy_q && dev_ack && last) || (start && !busy_q && !size_legal(size));
   assign set_err   = start && (busy_q || !size_legal(size));
   assign rx_load   = busy_q && dev_ack && last && rd_q;
   assign rx_val    = merged;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         rd_q    <= 1'b0;
         wr_q    <= 1'b0;
         base_q  <= '0;
         size_lq <= '0;
         tx_lq   <= '0;
         acc_q   <= '0;
         shift_q <= '0;
         mode_q  <= '0;
         beat_q  <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         rd_q    <= c_rd;
         wr_q    <= c_wr;
         base_q  <= addr;
         size_lq <= size;
         tx_lq   <= tx;
         acc_q   <= '0;
         shift_q <= port_shift(port_code);
         mode_q  <= mode;
         beat_q  <= '0;
      end else if (busy_q && dev_ack) begin
         if (last) begin
            busy_q <= 1'b0;
         end else begin
            beat_q <= beat_q + 1'b1;
            acc_q  <= merged;
         end
      end
   end
endmodule

// File: rtl/kcmd_engine.sv
module kcmd_engine
   import kcmd_pkg::*;
#(
   parameter int               ADDR_W  = 32,
   parameter int               KEY_W   = 16,
   parameter logic [KEY_W-1:0] CMD_KEY = 16'hA55A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_we,
   input  logic [2:0]        hst_addr,
   input  logic [31:0]       hst_wdata,
   output logic [31:0]       hst_rdata,
   input  logic [1:0]        cfg_kind,
   input  logic [1:0]        cfg_port,
   output logic              dev_req,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              dev_write,
   output logic              dev_read,
   output logic [3:0]        dev_mode,
   output logic [3:0]        dev_be,
   output logic [31:0]       dev_wdata,
   input  logic              dev_ack,
   input  logic [31:0]       dev_rdata
);
   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
         $error("kcmd_engine: ADDR_W must lie in 8..32");
      end
      if (KEY_W < 4 || KEY_W + MODE_W > 32) begin : g_bad_key_w
         $error("kcmd_engine: key and mode fields must fit the 32-bit command word");
      end
      if (WORD_W != 32) begin : g_bad_word
         $error("kcmd_engine: data word must be 32 bits");
      end
   endgenerate

   logic              eng_idle, set_done, set_err, rx_load, cmd_go;
   logic              flag_done, flag_err;
   logic [WORD_W-1:0] rx_val, tx_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SZ_W-1:0]   size_q;
   logic [MODE_W-1:0] cmd_mode;

   kcmd_regs #(.ADDR_W(ADDR_W), .KEY_W(KEY_W), .CMD_KEY(CMD_KEY)) u_regs (
      .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .idle(eng_idle),
      .set_done(set_done), .set_err(set_err), .rx_load(rx_load), .rx_val(rx_val),
      .addr_q(addr_q), .size_q(size_q), .tx_q(tx_q), .cmd_go(cmd_go),
      .cmd_mode(cmd_mode), .done_q(flag_done), .err_q(flag_err)
   );

   kcmd_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(cmd_go), .mode(cmd_mode), .kind(cfg_kind),
      .port_code(cfg_port), .addr(addr_q), .size(size_q), .tx(tx_q),
      .dev_ack(dev_ack), .dev_rdata(dev_rdata), .idle(eng_idle),
      .set_done(set_done), .set_err(set_err), .rx_load(rx_load), .rx_val(rx_val),
      .dev_req(dev_req), .dev_addr(dev_addr), .dev_write(dev_write),
      .dev_read(dev_read), .dev_mode(dev_mode), .dev_be(dev_be), .dev_wdata(dev_wdata)
   );
endmodule

// File: rtl/kcmd_engine_chk.sv
module kcmd_engine_chk #(
   parameter int               ADDR_W  = 32,
   parameter int               KEY_W   = 16,
   parameter logic [KEY_W-1:0] CMD_KEY = 16'hA55A
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hst_we,
   input logic [2:0]        hst_addr,
   input logic [31:0]       hst_wdata,
   input logic              idle,
   input logic              flag_done,
   input logic              flag_err,
   input logic [2:0]        size_cur,
   input logic              dev_req,
   input logic [ADDR_W-1:0] dev_addr,
   input logic              dev_write,
   input logic              dev_read,
   input logic [3:0]        dev_be,
   input logic [31:0]       dev_wdata,
   input logic              dev_ack
);
   logic cmd_wr, key_ok;
   assign cmd_wr = hst_we && (hst_addr == 3'd3);
   assign key_ok = hst_wdata[31 -: KEY_W] == CMD_KEY;

   assert_key_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && cmd_wr && !key_ok) |=> (!dev_req && $stable(flag_done) && $stable(flag_err)));

   assert_bad_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && cmd_wr && key_ok && (size_cur == 3'd0 || size_cur > 3'd4))
      |=> (flag_done && flag_err && !dev_req));

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_req && !dev_ack) |=> (dev_req && $stable(dev_addr) && $stable(dev_be)));

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_req && dev_ack) ##1 dev_req
      |-> (dev_addr == $past(dev_addr) + ADDR_W'($countones($past(dev_be)))));

   assert_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req |-> dev_be[0]);

   assert_no_be_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_req |-> (dev_be == 4'd0));

   assert_wdata_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_write |-> (dev_wdata == 32'd0));

   assert_one_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(dev_write && dev_read));

   assert_busy_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dev_req |-> !idle);

   assert_busy_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && cmd_wr && key_ok) |=> flag_err);
endmodule

bind kcmd_engine kcmd_engine_chk #(.ADDR_W(ADDR_W), .KEY_W(KEY_W), .CMD_KEY(CMD_KEY)) u_chk (
   .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
   .idle(eng_idle), .flag_done(flag_done), .flag_err(flag_err), .size_cur(size_q),
   .dev_req(dev_req), .dev_addr(dev_addr), .dev_write(dev_write), .dev_read(dev_read),
   .dev_be(dev_be), .dev_wdata(dev_wdata), .dev_ack(dev_ack)
);

// File: tb/sim_kcmd_engine.sv
`timescale 1ns/1ps
module sim_kcmd_engine;
   localparam int LAT = 3;
   localparam logic [15:0] KEY = 16'hA55A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hst_we = 1'b0;
   logic [2:0]  hst_addr = 3'd0;
   logic [31:0] hst_wdata = 32'd0;
   logic [31:0] hst_rdata;
   logic [1:0]  cfg_kind = 2'd1;
   logic [1:0]  cfg_port = 2'd0;
   logic        dev_req, dev_write, dev_read;
   logic [31:0] dev_addr, dev_wdata;
   logic [3:0]  dev_mode, dev_be;
   logic        dev_ack = 1'b0;
   logic [31:0] dev_rdata = 32'd0;

   int tests = 0, fails = 0, beats_seen = 0, lat_cnt = 0;
   bit finished = 1'b0;
   logic [31:0] exp_rx = 32'd0;
   logic [31:0] qa[$], qw[$];
   logic [3:0]  qb[$];
   logic [1:0]  qd[$];

   always #2.5 clk = ~clk;

   kcmd_engine u0 (.*);

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[7:0] + 8'h71, a[7:0] ^ 8'hA5, a[7:0] + 8'h33, ~a[7:0]};
   endfunction

   // mode classification written from the requirement table (R8)
   function automatic logic [1:0] cls(input logic [1:0] k, input logic [3:0] m);
      bit r, w;
      case (k)
         2'd0: begin r = (m == 8); w = (m == 9 || m == 10); end
         2'd1: begin r = (m == 2); w = (m == 3); end
         2'd2: begin r = (m == 0 || m == 2); w = (m == 1 || m == 3); end
         default: begin r = (m >= 4 && m <= 6); w = (m >= 1 && m <= 3); end
      endcase
      return {w, r};
   endfunction

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   // device stub: fixed-latency acknowledge
   always @(posedge clk) begin
      if (!rst_n) begin
         dev_ack <= 1'b0; lat_cnt <= 0;
      end else if (dev_ack) begin
         dev_ack <= 1'b0; lat_cnt <= 0;
      end else if (dev_req) begin
         if (lat_cnt == LAT - 1) begin
            dev_ack <= 1'b1; dev_rdata <= pat(dev_addr);
         end else lat_cnt <= lat_cnt + 1;
      end
   end

   // per-clock comparison of handshakes against the model queue
   always @(negedge clk) begin
      if (rst_n && dev_req && dev_ack) begin
         beats_seen++;
         if (qa.size() == 0) begin
            chk(1'b0, "R1 unexpected device access", dev_addr, 32'hFFFFFFFF);
         end else begin
            chk(dev_addr == qa[0], "R4 access address", dev_addr, qa[0]);
            chk(dev_be == qb[0], "R5 lane enables", {28'd0, dev_be}, {28'd0, qb[0]});
            chk(dev_wdata == qw[0], "R7 write data", dev_wdata, qw[0]);
            chk({dev_write, dev_read} == qd[0], "R8 direction", {30'd0, dev_write, dev_read}, {30'd0, qd[0]});
            void'(qa.pop_front()); void'(qb.pop_front());
            void'(qw.pop_front()); void'(qd.pop_front());
         end
      end
   end

   task automatic hwrite(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      hst_we = 1'b1; hst_addr = a; hst_wdata = d;
      @(negedge clk);
      hst_we = 1'b0;
   endtask

   task automatic hread(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      hst_addr = a;
      #1 d = hst_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 200; i++) begin
         hread(3'd5, s);
         if (s[2]) break;
      end
   endtask

   // load registers and build the expected access list
   task automatic prep(input logic [1:0] k, input logic [1:0] pc, input logic [31:0] a,
                       input int s, input logic [31:0] tx, input logic [3:0] m);
      int sh, p, nb;
      logic [1:0] d;
      logic [31:0] rx;
      sh = (pc == 0) ? 0 : (pc == 1) ? 1 : 2;
      p  = 1 << sh;
      nb = (s + p - 1) / p;
      d  = cls(k, m);
      cfg_kind = k; cfg_port = pc;
      hwrite(3'd0, a);
      hwrite(3'd1, s);
      hwrite(3'd2, tx);
      rx = 32'd0;
      for (int i = 0; i < nb; i++) begin
         logic [3:0] be; logic [31:0] wd;
         be = 4'd0; wd = 32'd0;
         for (int j = 0; j < p; j++) begin
            int b;
            b = i * p + j;
            if (b < s) begin
               be[j] = 1'b1;
               if (d[1]) wd[8*j +: 8] = tx[8*b +: 8];
               rx[8*b +: 8] = pat(a + i * p) >> (8 * j);
            end
         end
         qa.push_back(a + i * p); qb.push_back(be); qw.push_back(wd); qd.push_back(d);
      end
      if (d[0]) exp_rx = rx;
   endtask

   task automatic run_cmd(input logic [1:0] k, input logic [1:0] pc, input logic [31:0] a,
                          input int s, input logic [31:0] tx, input logic [3:0] m);
      logic [31:0] v;
      prep(k, pc, a, s, tx, m);
      hwrite(3'd3, {KEY, 12'd0, m});
      wait_idle();
      chk(qa.size() == 0, "R4 access count", qa.size(), 0);
      hread(3'd5, v);
      chk(v == 32'h5, "R9 done after completion", v, 32'h5);
      hread(3'd4, v);
      chk(v == exp_rx, "R6 receive register", v, exp_rx);
      hwrite(3'd5, 32'h1);
      hread(3'd5, v);
      chk(v == 32'h4, "R9 done cleared by write-1", v, 32'h4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int n0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      hread(3'd5, v); chk(v == 32'h4, "R11 reset status", v, 32'h4);
      hread(3'd4, v); chk(v == 32'h0, "R11 reset receive", v, 32'h0);
      hread(3'd0, v); chk(v == 32'h0, "R11 reset address", v, 32'h0);
      hread(3'd1, v); chk(v == 32'h70, "R11 reset size readback", v, 32'h70);

      // R3 derived lane masks
      hwrite(3'd1, 1); hread(3'd1, v); chk(v == 32'h71, "R3 masks size 1", v, 32'h71);
      hwrite(3'd1, 2); hread(3'd1, v); chk(v == 32'h62, "R3 masks size 2", v, 32'h62);
      hwrite(3'd1, 3); hread(3'd1, v); chk(v == 32'h43, "R3 masks size 3", v, 32'h43);
      hwrite(3'd1, 4); hread(3'd1, v); chk(v == 32'h04, "R3 masks size 4", v, 32'h04);

      // R1 wrong key is ignored
      n0 = beats_seen;
      hwrite(3'd3, {16'h1234, 12'd0, 4'd2});
      repeat (10) @(negedge clk);
      hread(3'd5, v); chk(v == 32'h4, "R1 wrong key no flags", v, 32'h4);
      chk(beats_seen == n0, "R1 wrong key no access", beats_seen, n0);
      hwrite(3'd3, {16'hA55B, 12'd0, 4'd3});
      repeat (10) @(negedge clk);
      hread(3'd5, v); chk(v == 32'h4, "R1 near-miss key no flags", v, 32'h4);

      // R2 illegal sizes
      for (int s = 0; s < 8; s += 5) begin
         n0 = beats_seen;
         hwrite(3'd1, s);
         hwrite(3'd3, {KEY, 12'd0, 4'd2});
         hread(3'd5, v); chk(v == 32'h7, "R2 illegal size flags", v, 32'h7);
         chk(beats_seen == n0, "R2 illegal size no access", beats_seen, n0);
         hwrite(3'd5, 32'h1);
         hread(3'd5, v); chk(v == 32'h6, "R9 clear done keeps error", v, 32'h6);
         hwrite(3'd5, 32'h2);
         hread(3'd5, v); chk(v == 32'h4, "R9 clear error", v, 32'h4);
      end

      // R4 R5 R6 R7: every size on every port width, write then read
      for (int pc = 0; pc < 3; pc++)
         for (int s = 1; s <= 4; s++) begin
            run_cmd(2'd1, 2'(pc), 32'h8000_0100 + 32'(pc * 16 + s * 4), s, 32'hC3B2_A190 + 32'(s), 4'd3);
            run_cmd(2'd1, 2'(pc), 32'h8000_0200 + 32'(pc * 16 + s * 4), s, 32'h0, 4'd2);
         end

      // R4 port code 3 behaves as 32 bits
      run_cmd(2'd1, 2'd3, 32'h0000_0040, 4, 32'h1122_3344, 4'd2);

      // R8 classification across kinds
      run_cmd(2'd0, 2'd1, 32'h0000_0300, 4, 32'h5566_7788, 4'd10);
      run_cmd(2'd0, 2'd1, 32'h0000_0310, 3, 32'h0, 4'd8);
      run_cmd(2'd0, 2'd1, 32'h0000_0320, 2, 32'hDEAD_BEEF, 4'd0);
      run_cmd(2'd2, 2'd0, 32'h0000_0330, 2, 32'h0, 4'd0);
      run_cmd(2'd2, 2'd2, 32'h0000_0340, 3, 32'h0A0B_0C0D, 4'd1);
      run_cmd(2'd3, 2'd1, 32'h0000_0350, 4, 32'h0, 4'd5);
      run_cmd(2'd3, 2'd0, 32'h0000_0360, 3, 32'h99AA_BBCC, 4'd2);
      run_cmd(2'd3, 2'd2, 32'h0000_0370, 4, 32'hFFFF_FFFF, 4'd9);

      // R10 command while busy is rejected
      prep(2'd1, 2'd0, 32'h0000_0400, 4, 32'h0, 4'd2);
      hwrite(3'd3, {KEY, 12'd0, 4'd2});
      hwrite(3'd3, {KEY, 12'd0, 4'd3});
      hread(3'd5, v); chk(v[1] == 1'b1, "R10 busy command sets error", v, 32'h2);
      wait_idle();
      chk(qa.size() == 0, "R10 running command completes", qa.size(), 0);
      hread(3'd5, v); chk(v == 32'h7, "R10 final status", v, 32'h7);
      hread(3'd4, v); chk(v == exp_rx, "R10 receive of first command", v, exp_rx);
      n0 = beats_seen;
      repeat (10) @(negedge clk);
      chk(beats_seen == n0, "R10 rejected command never runs", beats_seen, n0);
      hwrite(3'd5, 32'h3);
      hread(3'd5, v); chk(v == 32'h4, "R9 both flags cleared", v, 32'h4);

      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule